// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Controller

This block is the digital wrapper around an analog voltage comparator. Software programs a small register window. It turns the comparator on, picks one of sixteen reference levels for the analog reference selector, and enables the interrupt. It reads the comparator result from a status register. The comparator output enters the block as an asynchronous digital signal. It passes through a synchronizer before any logic uses it.

The interrupt does not fire on a fixed edge or level. Each read of the status register takes a snapshot of the current result. Once the interrupt path is armed, any difference between the live result and that snapshot sets a sticky flag. Software clears the flag with the same register read it uses to inspect the flag, so the snapshot is refreshed as a side effect. A settle counter reports when the result is valid after the comparator has been enabled.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0, and `irq`, `ready`, `cmp_en` and `thr_sel` are all 0.
- R2: The control register (address 0) holds enable in bit 0, interrupt enable in bit 1 and the threshold code in bits 7:4. Bits 3:2 read as 0. `cmp_en` follows bit 0 and `thr_sel` follows bits 7:4. Code 4'b1000 is the code for a reference of 19/30 of the supply.
- R3: Status bit 0 (address 1) returns the comparator input after a two-flop synchronizer while the block is enabled. It reads 0 while the block is disabled.
- R4: `ready` (also status bit 2) rises exactly SETTLE_CYCLES clocks after the clock edge that sets enable. It is low while the block is disabled, and it restarts from zero each time the block is re-enabled.
- R5: Setting interrupt enable does not arm detection by itself. No flag is raised until a status read has occurred with interrupt enable set.
- R6: Once detection is armed, a difference between the synchronized result and the snapshot sets the flag (status bit 1) and raises `irq`.
- R7: Every status read copies the current result into the snapshot, so a result equal to the last value read raises no flag.
- R8: A write of 0 to status bit 1 clears the flag only if a status read has returned the flag as 1 since the last clear. Otherwise the flag stays set.
- R9: Clearing interrupt enable disarms detection. Later result changes set no flag until a new status read is made with interrupt enable set.
- R10: A mismatch present in the same cycle as a valid clear keeps the flag set.
- R11: `irq` is high exactly when the flag and interrupt enable are both 1. The flag itself is kept while interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered one clock after the read strobe |
| cmp_in | input | 1 | Asynchronous comparator output |
| cmp_en | output | 1 | Comparator power/enable |
| thr_sel | output | 4 | Reference level code for the analog selector |
| ready | output | 1 | Result has settled |
| irq | output | 1 | Interrupt request |

## Verification
The detector is driven with all four pairs of snapshot value and later live value, so a correct design flags exactly the two unequal pairs. A detector that fires on edges, or that ignores the snapshot, misreports at least one pair. Every threshold code is written and read back to expose a field-position fault. Separate sequences target the ordering rules: a clear written without a prior read, a clear that collides with a standing mismatch, and interrupt enable set with no arming read. Each of these tells a correct priority or arming rule from a reversed one. The settle time is checked on the clock before `ready` is due and on the clock when it is due.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_THR  = 4;
  localparam int STAT_RES  = 0;
  localparam int STAT_FLAG = 1;
  localparam int STAT_RDY  = 2;
  localparam logic [3:0] THR_19_30 = 4'b1000;

  typedef struct packed {
    logic [3:0] thr;
    logic       ie;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_settle.sv
module cmp_settle #(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ready
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt;

  // Held at zero while disabled, so every re-enable starts a fresh count.
  always_ff @(posedge clk) begin
    if (rst || !en)       cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ready = en && (cnt == LIMIT);
endmodule

// File: rtl/cmp_change_det.sv
module cmp_change_det (
  input  logic clk,
  input  logic rst,
  input  logic ie,
  input  logic stat_rd,
  input  logic clr_wr,
  input  logic result,
  output logic flag,
  output logic armed,
  output logic snap
);
  logic seen;
  logic mismatch;
  logic clear_ok;

  assign mismatch = armed && (result != snap);
  assign clear_ok = clr_wr && seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap  <= 1'b0;
      armed <= 1'b0;
      flag  <= 1'b0;
      seen  <= 1'b0;
    end else begin
      if (stat_rd) snap <= result;

      if (!ie)          armed <= 1'b0;
      else if (stat_rd) armed <= 1'b1;

      // A new mismatch wins over a clear in the same cycle.
      if (mismatch)      flag <= 1'b1;
      else if (clear_ok) flag <= 1'b0;

      if (clear_ok && !mismatch) seen <= 1'b0;
      else if (stat_rd && flag)  seen <= 1'b1;
    end
  end
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cmp_in,
  output logic       cmp_en,
  output logic [3:0] thr_sel,
  output logic       ready,
  output logic       irq
);
  ctrl_t ctrl;
  logic  live;
  logic  result;
  logic  flag;
  logic  armed;
  logic  snap;
  logic  stat_rd;
  logic  ctrl_wr;
  logic  clr_wr;

  assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);
  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign clr_wr  = reg_wr && (reg_addr == ADDR_STAT) && !reg_wdata[STAT_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl.en  <= reg_wdata[CTRL_EN];
      ctrl.ie  <= reg_wdata[CTRL_IE];
      ctrl.thr <= reg_wdata[CTRL_THR +: 4];
    end
  end

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_in),
    .q   (live)
  );

  assign result = ctrl.en && live;

  cmp_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk   (clk),
    .rst   (rst),
    .en    (ctrl.en),
    .ready (ready)
  );

  cmp_change_det u_det (
    .clk     (clk),
    .rst     (rst),
    .ie      (ctrl.ie),
    .stat_rd (stat_rd),
    .clr_wr  (clr_wr),
    .result  (result),
    .flag    (flag),
    .armed   (armed),
    .snap    (snap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_addr == ADDR_CTRL)
        reg_rdata <= {ctrl.thr, 2'b00, ctrl.ie, ctrl.en};
      else
        reg_rdata <= {5'b0, ready, flag, result};
    end
  end

  assign cmp_en  = ctrl.en;
  assign thr_sel = ctrl.thr;
  assign irq     = flag && ctrl.ie;
endmodule

// File: rtl/cmp_irq_checker.sv
module cmp_irq_checker (
  input logic clk,
  input logic rst,
  input logic irq,
  input logic ie,
  input logic ready,
  input logic cmp_en,
  input logic flag,
  input logic armed,
  input logic snap,
  input logic result,
  input logic clr_wr
);
  p_irq_needs_ie_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> ie);

  p_ready_off_r4: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |-> !ready);

  p_ready_restart_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_en) |-> !ready);

  p_mismatch_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && (result != snap)) |=> flag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_wr) |=> flag);

  p_disarm_r9: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !armed);
endmodule

bind cmp_irq_ctrl cmp_irq_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .ie     (ctrl.ie),
  .ready  (ready),
  .cmp_en (cmp_en),
  .flag   (flag),
  .armed  (armed),
  .snap   (snap),
  .result (result),
  .clr_wr (clr_wr)
);

// File: tb/cmp_irq_ctrl_bench.sv
module cmp_irq_ctrl_bench;
  localparam int SETTLE = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cmp_in = 1'b0;
  logic       cmp_en;
  logic [3:0] thr_sel;
  logic       ready;
  logic       irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cmp_irq_ctrl #(.SETTLE_CYCLES(SETTLE)) u_cmp_irq_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_in(cmp_in), .cmp_en(cmp_en), .thr_sel(thr_sel),
    .ready(ready), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic drive_in(input logic v);
    @(negedge clk);
    cmp_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 ready", ready, 0);
    chk("R1 cmp_en", cmp_en, 0);
    chk("R1 thr_sel", thr_sel, 0);
    rd(1'b0, d); chk("R1 ctrl", d, 0);
    rd(1'b1, d); chk("R1 stat", d, 0);

    // R2 threshold field sweep with enable off
    for (int t = 0; t < 16; t++) begin
      wr(1'b0, {t[3:0], 4'b1100});
      chk("R2 thr_sel", thr_sel, t);
      rd(1'b0, d);
      chk("R2 ctrl readback", d, t << 4);
    end
    wr(1'b0, {4'b1000, 4'b0000});
    chk("R2 code 19/30", thr_sel, 8);

    // R3 result forced to 0 while disabled
    drive_in(1'b1);
    rd(1'b1, d); chk("R3 disabled result", d[0], 0);

    // R4 settle timing
    wr(1'b0, 8'h81);
    chk("R2 cmp_en", cmp_en, 1);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R4 ready early", ready, 0);
    @(negedge clk);
    chk("R4 ready on time", ready, 1);
    rd(1'b1, d);
    chk("R3 result high", d[0], 1);
    chk("R4 ready status bit", d[2], 1);
    drive_in(1'b0);
    rd(1'b1, d); chk("R3 result low", d[0], 0);

    // R5 interrupt enable without an arming read
    wr(1'b0, 8'h83);
    drive_in(1'b1);
    chk("R5 no irq before arming read", irq, 0);
    rd(1'b1, d); chk("R5 no flag before arming read", d[1], 0);

    // R6/R7 sweep over snapshot and later value
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 2; n++) begin
        drive_in(s[0]);
        rd(1'b1, d);
        wr(1'b1, 8'h00);
        chk("R7 cleared before step", irq, 0);
        drive_in(n[0]);
        chk("R6 irq vs snapshot", irq, int'(s != n));
        rd(1'b1, d);
        chk("R7 flag vs snapshot", d[1], int'(s != n));
      end
    end

    // R8: clear without a prior read of 1 is ignored (snapshot=1, seen=0)
    drive_in(1'b0);
    chk("R6 flag set", irq, 1);
    wr(1'b1, 8'h00);
    chk("R8 clear without read ignored", irq, 1);
    rd(1'b1, d);
    chk("R8 read shows flag", d[1], 1);
    wr(1'b1, 8'h00);
    chk("R8 clear after read", irq, 0);

    // R10: mismatch standing during the clear keeps the flag
    drive_in(1'b1);
    chk("R6 flag set again", irq, 1);
    rd(1'b1, d);
    drive_in(1'b0);
    wr(1'b1, 8'h00);
    chk("R10 mismatch beats clear", irq, 1);
    rd(1'b1, d);
    wr(1'b1, 8'h00);
    chk("R10 later clear", irq, 0);

    // R11: irq masked by interrupt enable, flag kept
    drive_in(1'b1);
    chk("R11 irq with ie", irq, 1);
    wr(1'b0, 8'h81);
    chk("R11 irq masked", irq, 0);
    rd(1'b1, d);
    chk("R11 flag kept", d[1], 1);
    wr(1'b1, 8'h00);

    // R9: disarmed, changes ignored even after ie is set again
    drive_in(1'b0);
    rd(1'b1, d);
    chk("R9 no flag while disarmed", d[1], 0);
    wr(1'b0, 8'h83);
    drive_in(1'b1);
    chk("R9 ie alone does not rearm", irq, 0);
    rd(1'b1, d);
    chk("R9 flag still clear", d[1], 0);

    // R4/R3 disable
    wr(1'b0, 8'h00);
    chk("R4 ready off when disabled", ready, 0);
    rd(1'b1, d);
    chk("R3 result zero when disabled", d[0], 0);
    wr(1'b0, 8'h01);
    chk("R4 ready restarts", ready, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule